// File: doc/BRIEF.md
# Byte-Bus GPIO and Interrupt Expander

This block is a small peripheral that sits on an 8-bit host bus. It gives the host five bytes of general output bits, and each bit drives one output pin. It also gathers eight external interrupt inputs into one active-high request line.

Each interrupt input is synchronised into the clock domain. A rising edge latches the input into a sticky status bit, and the host clears that bit by writing a one to it. A read/write enable mask decides which status bits reach the request line. The request line stays high as long as any enabled status bit is set. Before the host sleeps, it can reload the mask with only the wake sources enabled. The request line keeps working in that state, so an enabled input can still wake the host.

Top module: `ioexp_top`

## Requirements
- R1: After reset, all five output bytes, the mask, the status and the read data are 0x00, and `host_irq` is low.
- R2: A write with `cs` and `wr` high loads an output byte, and the new value appears on `misc_out` after that clock edge. Byte 1 is at address 0xA, bytes 2 to 5 are at 0x0, 0x2, 0x4 and 0x6, and byte k drives `misc_out[8k-1:8k-8]`.
- R3: A read with `cs` and `rd` high registers the read data. `rdata` is valid after the edge that samples the strobe and holds until the next read. Output byte 1 reads back at 0xA. Reads of bytes 2 to 5 return no defined value, so the host keeps its own copy.
- R4: A read at address 0x8 returns the live input levels as seen through a two-stage synchroniser. An input change becomes visible to a read strobe sampled on the third edge after the change.
- R5: A rising edge on input bit i sets status bit i, which reads at 0xE. The bit sets whether or not the input is masked. A falling edge does not change status.
- R6: A write to 0xE clears every status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R7: When a new rising edge on bit i is latched in the same cycle as a clear of bit i, the bit stays set.
- R8: Input bit 2 has no source, and its status bit never sets, even when that input rises.
- R9: The mask at address 0xC can be written and read back. A mask bit of 1 enables its source and 0 disables it.
- R10: `host_irq` is high exactly while some status bit and its mask bit are both 1. It rises in the cycle the status bit latches, and it falls after a clear or a mask write removes the last enabled bit.
- R11: Bus strobes are ignored while `cs` is low: no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Asynchronous interrupt inputs |
| misc_out | output | 40 | Output pins, byte 1 in the low bits |
| host_irq | output | 1 | Active-high level request to the host |

## Verification
Each result has its own latency:
- An output byte is valid one edge after its write.
- Read data is valid one edge after its strobe.
- An input level shows on the third read strobe after the change.
- Status latches on the third edge after an input rise, and `host_irq` follows in that same cycle.

The bench drives inputs on the falling edge. A scoreboard queue holds the expected value for each read, and the monitor pops it on the falling edge that follows the sampling edge. Back-to-back reads taken right after an input change therefore expect the old value, the old value, then the new one. The clear-collision case schedules the clear write so that it lands on the edge where the synchronised rise is latched.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int NMISC = 5;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    localparam addr_t A_LEVEL = 4'h8;
    localparam addr_t A_MASK  = 4'hC;
    localparam addr_t A_STAT  = 4'hE;

    // inputs without a source: status never sets
    localparam byte_t NC_BITS = 8'h04;

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        byte_t data;
    } bus_req_t;

    // output byte index 0 (byte 1) sits apart from the even-address group
    function automatic addr_t misc_addr(input int idx);
        return (idx == 0) ? addr_t'(4'hA) : addr_t'((idx - 1) * 2);
    endfunction
endpackage

// File: rtl/ioexp_sync.sv
module ioexp_sync
    import ioexp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t pin_in,
    output byte_t level,
    output byte_t rise
);
    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], pin_in[b]};
        end
        assign level[b] = sh[1];
        assign rise[b]  = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/ioexp_irq.sv
module ioexp_irq
    import ioexp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stat_we,
    input  logic  mask_we,
    input  byte_t wdata,
    input  byte_t rise,
    output byte_t status,
    output byte_t mask
);
    byte_t clr;
    assign clr = stat_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            if (mask_we) mask <= wdata;
            // a fresh edge outranks a clear of the same bit
            status <= ((status & ~clr) | rise) & ~NC_BITS;
        end
    end
endmodule

// File: rtl/ioexp_misc.sv
module ioexp_misc
    import ioexp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  addr_t              addr,
    input  byte_t              wdata,
    output logic [NMISC*DW-1:0] regs
);
    for (genvar g = 0; g < NMISC; g++) begin : g_reg
        localparam addr_t MY_ADDR = misc_addr(g);
        always_ff @(posedge clk) begin
            if (rst)                        regs[g*DW +: DW] <= '0;
            else if (we && addr == MY_ADDR) regs[g*DW +: DW] <= wdata;
        end
    end
endmodule

// File: rtl/ioexp_top.sv
module ioexp_top
    import ioexp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    input  logic [DW-1:0]           irq_in,
    output logic [NMISC*DW-1:0]     misc_out,
    output logic                    host_irq
);
    bus_req_t req;
    byte_t    level_w, rise_w, status_q, mask_q, rd_mux;

    assign req = '{wr: cs & wr, rd: cs & rd, addr: addr, data: wdata};

    ioexp_sync u_sync (
        .clk(clk), .rst(rst), .pin_in(irq_in), .level(level_w), .rise(rise_w)
    );

    ioexp_irq u_irq (
        .clk(clk), .rst(rst),
        .stat_we(req.wr && req.addr == A_STAT),
        .mask_we(req.wr && req.addr == A_MASK),
        .wdata(req.data), .rise(rise_w),
        .status(status_q), .mask(mask_q)
    );

    ioexp_misc u_misc (
        .clk(clk), .rst(rst), .we(req.wr), .addr(req.addr),
        .wdata(req.data), .regs(misc_out)
    );

    always_comb begin
        // write-only bytes read as zero; software must not rely on it
        if      (req.addr == A_LEVEL)      rd_mux = level_w;
        else if (req.addr == A_MASK)       rd_mux = mask_q;
        else if (req.addr == A_STAT)       rd_mux = status_q;
        else if (req.addr == misc_addr(0)) rd_mux = misc_out[DW-1:0];
        else                               rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= rd_mux;
    end

    assign host_irq = |(status_q & mask_q);
endmodule

// File: rtl/ioexp_chk.sv
module ioexp_chk
    import ioexp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cs,
    input logic               wr,
    input addr_t              addr,
    input byte_t              wdata,
    input byte_t              rise,
    input byte_t              status,
    input byte_t              mask,
    input logic               host_irq,
    input logic [NMISC*DW-1:0] misc_out
);
    logic stat_wr;
    assign stat_wr = cs && wr && addr == A_STAT;

    // R1
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (status == '0 && mask == '0 && misc_out == '0 && !host_irq));

    // R5: set bits hold unless the host clears them
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((status & $past(status)) == $past(status)));

    // R6
    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((status & $past(wdata & ~rise)) == '0));

    // R7: an edge always latches, clear or not
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((status & $past(rise & ~NC_BITS)) == $past(rise & ~NC_BITS)));

    // R8
    a_r8_nc_bit: assert property (@(posedge clk) disable iff (rst)
        (status & NC_BITS) == '0);

    // R10
    a_r10_no_mask_no_irq: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !host_irq);

    a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (status != '0));

    // R11
    a_r11_no_cs: assert property (@(posedge clk) disable iff (rst)
        !cs |=> ($stable(mask) && $stable(misc_out)));
endmodule

bind ioexp_top ioexp_chk i_chk (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
    .rise(rise_w), .status(status_q), .mask(mask_q), .host_irq(host_irq),
    .misc_out(misc_out)
);

// File: tb/test_ioexp_top.sv
module test_ioexp_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        cs = 0, wr = 0, rd = 0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  irq_in = '0;
    logic [39:0] misc_out;
    logic        host_irq;

    int total = 0;
    int bad   = 0;

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t sbq[$];
    logic pend = 0;

    always #5 clk = ~clk;

    ioexp_top i_ioexp_top (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .misc_out(misc_out),
        .host_irq(host_irq)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop one expected item per sampled read
    always @(posedge clk) pend <= cs && rd && !rst;
    always @(negedge clk) begin
        if (pend) begin
            if (sbq.size() == 0) check(1, 0, "scoreboard underflow");
            else begin
                exp_t e;
                e = sbq.pop_front();
                check(rdata, e.v, e.tag);
            end
        end
    end

    // tasks start and end just after a falling edge
    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        cs = 1; rd = 1; addr = a;
        sbq.push_back('{v: exp, tag: tag});
        @(negedge clk);
        cs = 0; rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [7:0] M1 = 8'h3C, M2 = 8'h81, M3 = 8'h5A, M4 = 8'hF0, M5 = 8'h07;

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // R1
        check(misc_out, 40'h0, "R1 misc_out");
        check(host_irq, 0, "R1 host_irq");
        check(rdata, 0, "R1 rdata");
        bus_rd(4'hE, 8'h00, "R1 status");
        bus_rd(4'hC, 8'h00, "R1 mask");

        // R2, R3
        bus_wr(4'hA, M1);
        check(misc_out[7:0], M1, "R2 byte1 after one edge");
        bus_wr(4'h0, M2);
        bus_wr(4'h2, M3);
        bus_wr(4'h4, M4);
        bus_wr(4'h6, M5);
        check(misc_out, {M5, M4, M3, M2, M1}, "R2 all bytes");
        bus_rd(4'hA, M1, "R3 byte1 readback");
        idle(2);
        check(rdata, M1, "R3 rdata holds");

        // R11
        wr = 1; addr = 4'hA; wdata = 8'hEE; cs = 0;
        idle(1);
        addr = 4'hC; idle(1);
        wr = 0;
        check(misc_out[7:0], M1, "R11 byte1 unchanged");
        bus_rd(4'hC, 8'h00, "R11 mask unchanged");

        // R4 latency with R5/R8: inputs rise including unconnected bit 2
        irq_in = 8'hA5;
        bus_rd(4'h8, 8'h00, "R4 level edge1");
        bus_rd(4'h8, 8'h00, "R4 level edge2");
        bus_rd(4'h8, 8'hA5, "R4 level edge3");
        bus_rd(4'hE, 8'hA1, "R5 R8 status latched, bit2 excluded");
        check(host_irq, 0, "R10 masked, no irq");

        // R5: falling edges leave status
        irq_in = 8'h00;
        idle(4);
        bus_rd(4'hE, 8'hA1, "R5 fall no change");

        // R6
        bus_wr(4'hE, 8'h01);
        bus_rd(4'hE, 8'hA0, "R6 clear bit0");
        bus_wr(4'hE, 8'h00);
        bus_rd(4'hE, 8'hA0, "R6 zero write keeps");

        // R9, R10
        bus_wr(4'hC, 8'h20);
        bus_rd(4'hC, 8'h20, "R9 mask readback");
        check(host_irq, 1, "R10 enabled bit raises irq");
        bus_wr(4'hE, 8'h20);
        check(host_irq, 0, "R10 clear drops irq");
        bus_wr(4'hC, 8'h80);
        check(host_irq, 1, "R10 bit7 enabled");
        bus_wr(4'hC, 8'h00);
        check(host_irq, 0, "R10 mask drops irq");

        // R10 timing on a wake-source mask
        bus_wr(4'hC, 8'h02);
        irq_in = 8'h02;
        idle(2);
        check(host_irq, 0, "R10 not yet at edge2");
        idle(1);
        check(host_irq, 1, "R10 high at edge3");

        // R7: bit1 set, input low, then new rise meets a clear
        irq_in = 8'h00;
        idle(3);
        irq_in = 8'h02;
        idle(2);
        bus_wr(4'hE, 8'h02);
        bus_rd(4'hE, 8'h82, "R7 set beats clear");
        check(host_irq, 1, "R7 irq stays");
        bus_wr(4'hE, 8'h82);
        bus_rd(4'hE, 8'h00, "R6 clear all");
        check(host_irq, 0, "R10 idle after clear");

        // R8: only bit 2 rising
        irq_in = 8'h04;
        idle(4);
        bus_rd(4'hE, 8'h00, "R8 bit2 never sets");

        idle(2);
        check(sbq.size(), 0, "scoreboard drained");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule